// File: doc/BRIEF.md
# Serial Register Address Pointer with Half Indicator

This block keeps the read/write position into a 512-entry serial register that is split into a lower half (positions 0 to 255) and an upper half (positions 256 to 511). A transfer cycle ends with a start position being loaded. Each serial clock then moves the pointer on by one. A half indicator shows the software-visible side of the register that the pointer is on.

There are two kinds of load. A full load moves the pointer straight to the given start position and sets the half indicator from that position's top bit. A split load does not move the pointer. It records a start position for the half that is not being accessed. When the pointer later runs off the end of its current half, it goes to the recorded position instead of to the next sequential one. The serial clock is presented as a one-cycle step strobe in the block's clock domain.

Top module: `sptr_unit`

## Requirements
- R1: After reset, ptr is 0 and half_flag is 0, and no split start position is recorded.
- R2: A full load (tap_load=1, tap_split=0) sets ptr to tap_addr and half_flag to tap_addr[8] in the cycle after the load. It also discards any recorded split start position.
- R3: A step (step=1, no load) away from a half boundary sets ptr to ptr+1. From 511 with nothing recorded, ptr goes to 0.
- R4: half_flag is 0 while ptr is in 0..255 and 1 while ptr is in 256..511. It changes state on every step that leaves position 255 or 511.
- R5: A split load (tap_load=1, tap_split=1) leaves ptr and half_flag unchanged. It records tap_addr[7:0] as the start for the half opposite ptr[8], and tap_addr[8] is ignored.
- R6: A step from position 255 or 511 while a split start is recorded sets ptr to {~ptr[8], recorded[7:0]} and clears the record. Later steps then count sequentially.
- R7: When tap_load and step are both high, the load takes effect and the step is dropped.
- R8: A second split load before the record is used replaces the earlier recorded position.
- R9: With tap_load=0 and step=0, ptr and half_flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Serial clock strobe, one position per high cycle |
| tap_load | input | 1 | Load strobe marking the end of a transfer cycle |
| tap_split | input | 1 | 1 for a split load, 0 for a full load |
| tap_addr | input | 9 | Start position carried by the load |
| ptr | output | 9 | Current serial pointer |
| half_flag | output | 1 | Half indicator, 1 while in the upper half |

## Verification
Both outputs come from registers. The effect of a load or a step therefore appears one cycle after the rising edge that accepts it. A split record only shows up when a later step leaves a half boundary. The bench drives every input on the falling edge and compares ptr and half_flag at the next falling edge against its own model of the requirements. Each check sits exactly one registered cycle after its stimulus. The record is verified indirectly through the position that the crossing step produces.

// File: rtl/sptr_pkg.sv
package sptr_pkg;
    // Action selected for a cycle, in priority order: loads before steps.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_FULL  = 2'd1,
        ACT_SPLIT = 2'd2,
        ACT_STEP  = 2'd3
    } act_e;
endpackage

// File: rtl/sptr_decode.sv
module sptr_decode
    import sptr_pkg::*;
(
    input  logic tap_load,
    input  logic tap_split,
    input  logic step,
    output act_e act
);
    always_comb begin
        if (tap_load) begin
            act = tap_split ? ACT_SPLIT : ACT_FULL;
        end else if (step) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end
endmodule

// File: rtl/sptr_advance.sv
module sptr_advance #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] ptr_cur,
    input  logic              pend_valid,
    input  logic [ADDR_W-2:0] pend_low,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              at_edge,
    output logic              take_pend
);
    localparam int LOW_W = ADDR_W - 1;

    logic [ADDR_W-1:0] seq_addr;

    always_comb begin
        seq_addr  = ptr_cur + 1'b1;
        at_edge   = &ptr_cur[LOW_W-1:0];
        take_pend = at_edge & pend_valid;
        if (take_pend) begin
            ptr_next = {~ptr_cur[ADDR_W-1], pend_low};
        end else begin
            ptr_next = seq_addr;
        end
    end
endmodule

// File: rtl/sptr_pend.sv
module sptr_pend
    import sptr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [ADDR_W-1:0] tap_addr,
    input  logic              take_pend,
    output logic              pend_valid,
    output logic [ADDR_W-2:0] pend_low
);
    localparam int LOW_W = ADDR_W - 1;

    typedef struct packed {
        logic             valid;
        logic [LOW_W-1:0] low;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        case (act)
            ACT_FULL:  pend_d.valid = 1'b0;
            ACT_SPLIT: begin
                pend_d.valid = 1'b1;
                pend_d.low   = tap_addr[LOW_W-1:0];
            end
            ACT_STEP:  if (take_pend) pend_d.valid = 1'b0;
            default:   pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_valid = pend_q.valid;
    assign pend_low   = pend_q.low;

    // R5, R8: a split load leaves the latest low bits on record
    p_pend_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SPLIT) |=> (pend_valid && pend_low == $past(tap_addr[LOW_W-1:0])));

    // R2: a full load drops the record
    p_pend_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_FULL) |=> !pend_valid);
endmodule

// File: rtl/sptr_unit.sv
module sptr_unit
    import sptr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              tap_load,
    input  logic              tap_split,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic [ADDR_W-1:0] ptr,
    output logic              half_flag
);
    localparam int LOW_W = ADDR_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              flag;
    } core_t;

    core_t core_d, core_q;

    act_e              act;
    logic              pend_valid;
    logic [LOW_W-1:0]  pend_low;
    logic [ADDR_W-1:0] ptr_next;
    logic              at_edge;
    logic              take_pend;
    logic              take_gated;

    sptr_decode u_decode (
        .tap_load  (tap_load),
        .tap_split (tap_split),
        .step      (step),
        .act       (act)
    );

    sptr_advance #(.ADDR_W(ADDR_W)) u_advance (
        .ptr_cur    (core_q.ptr),
        .pend_valid (pend_valid),
        .pend_low   (pend_low),
        .ptr_next   (ptr_next),
        .at_edge    (at_edge),
        .take_pend  (take_pend)
    );

    assign take_gated = take_pend & (act == ACT_STEP);

    sptr_pend #(.ADDR_W(ADDR_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .tap_addr   (tap_addr),
        .take_pend  (take_gated),
        .pend_valid (pend_valid),
        .pend_low   (pend_low)
    );

    // The flag is kept separately: it loads from the tap top bit and toggles on half exit.
    always_comb begin
        core_d = core_q;
        case (act)
            ACT_FULL: begin
                core_d.ptr  = tap_addr;
                core_d.flag = tap_addr[ADDR_W-1];
            end
            ACT_STEP: begin
                core_d.ptr  = ptr_next;
                core_d.flag = at_edge ? ~core_q.flag : core_q.flag;
            end
            default: core_d = core_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign ptr       = core_q.ptr;
    assign half_flag = core_q.flag;

    // R4: flag always agrees with the pointer's half
    p_flag_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_flag == ptr[ADDR_W-1]);

    // R2, R7: full load wins and lands the tap
    p_full_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_load && !tap_split) |=> (ptr == $past(tap_addr)));

    // R5: split load does not move the pointer
    p_split_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_load && tap_split) |=> ($stable(ptr) && $stable(half_flag)));

    // R3: sequential step inside a half
    p_step_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !tap_load && (ptr[LOW_W-1:0] != {LOW_W{1'b1}}))
        |=> (ptr == $past(ptr) + 1'b1));

    // R6: leaving a half always flips the half
    p_edge_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !tap_load && (ptr[LOW_W-1:0] == {LOW_W{1'b1}}))
        |=> (half_flag != $past(half_flag)));

    // R9: idle holds
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !tap_load) |=> $stable(ptr));
endmodule

// File: tb/sim_sptr_unit.sv
`timescale 1ns/1ps
module sim_sptr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic       tap_load = 1'b0;
    logic       tap_split = 1'b0;
    logic [8:0] tap_addr = '0;
    logic [8:0] ptr;
    logic       half_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [8:0] ep = '0;
    logic       pv = 1'b0;
    logic [7:0] pl = '0;

    always #5 clk = ~clk;

    sptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .tap_load(tap_load),
        .tap_split(tap_split), .tap_addr(tap_addr), .ptr(ptr), .half_flag(half_flag)
    );

    task automatic check(input string req);
        checks++;
        if (ptr !== ep || half_flag !== ep[8]) begin
            errors++;
            $display("FAIL %s: ptr=%0d flag=%0b expected ptr=%0d flag=%0b",
                     req, ptr, half_flag, ep, ep[8]);
        end
    endtask

    // drive at negedge, outputs registered at posedge, compare at following negedge
    task automatic cyc(input bit ld, input bit sp, input logic [8:0] a, input bit st,
                       input string req);
        tap_load = ld; tap_split = sp; tap_addr = a; step = st;
        if (ld && !sp) begin
            ep = a; pv = 1'b0;
        end else if (ld && sp) begin
            pv = 1'b1; pl = a[7:0];
        end else if (st) begin
            if (ep[7:0] == 8'hFF && pv) begin
                ep = {~ep[8], pl}; pv = 1'b0;
            end else begin
                ep = ep + 9'd1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        tap_load = 1'b0; step = 1'b0;
        check(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: every tap position through a full load
        for (int a = 0; a < 512; a++) cyc(1, 0, a[8:0], 0, "R2");

        // R3 / R4: full walk with wrap
        cyc(1, 0, 9'd0, 0, "R2");
        for (int i = 0; i < 520; i++)
            cyc(0, 0, 9'd0, 1, (ep[7:0] == 8'hFF) ? "R4" : "R3");

        // R5, R6, R7, R9: split record into the opposite half, every low value
        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p < 256; p++) begin
                cyc(1, 0, {h[0], 8'hFD}, 0, "R2");
                cyc(1, 1, {p[1], p[7:0]}, 0, "R5");
                cyc(0, 0, 9'd0, 0, "R9");
                if (p % 16 == 0) cyc(1, 1, {p[0], p[7:0]}, 1, "R7");
                cyc(0, 0, 9'd0, 1, "R3");
                cyc(0, 0, 9'd0, 1, "R3");
                cyc(0, 0, 9'd0, 1, "R6");
                if (p[7:0] != 8'hFF) cyc(0, 0, 9'd0, 1, "R6");
            end
        end

        // R8: newer split record replaces the older
        cyc(1, 0, 9'h0FE, 0, "R2");
        cyc(1, 1, 9'h010, 0, "R5");
        cyc(1, 1, 9'h020, 0, "R8");
        cyc(0, 0, 9'd0, 1, "R3");
        cyc(0, 0, 9'd0, 1, "R8");

        // R2: full load discards a pending record
        cyc(1, 1, 9'h033, 0, "R5");
        cyc(1, 0, 9'h0FF, 0, "R2");
        cyc(0, 0, 9'd0, 1, "R2");

        // R7: full load with a step in the same cycle
        cyc(1, 0, 9'h1FF, 1, "R7");
        cyc(0, 0, 9'd0, 1, "R4");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: expected completion, got timeout");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule